// File: doc/BRIEF.md
# Edge Capture Unit with Prescaler

This unit records the value of an external free-running 16-bit timer whenever a selected event occurs. The event is chosen by a 4-bit mode written over a simple register bus. It can be a falling edge or a rising edge of an input pin, one rising edge out of every four or every sixteen, or a single-cycle timestamp strobe from a message controller. Each capture loads the capture register and raises an interrupt flag. The flag stays high until software clears it.

The pin arrives already synchronized to the clock. The unit finds edges by comparing the pin with its sample from the previous cycle. A small counter inside the unit divides rising edges for the two prescaled modes. The counter restarts on every mode write and is held at zero while the unit is off. Because of this, the first prescaled capture after a mode change always needs the full number of edges. The timer, the bus decoding and the pin synchronizer are outside the unit.

Top module: `edge_capture_unit`

## Requirements
- R1: With mode 4'b0101 the capture register loads `timer_i` at every clock edge where `pin_i` is 1 and its previous-cycle sample was 0.
- R2: With mode 4'b0100 the capture register loads `timer_i` at every clock edge where `pin_i` is 0 and its previous-cycle sample was 1. Rising edges capture nothing.
- R3: With mode 4'b0110 only every fourth rising edge captures. The first capture comes on the fourth rising edge after the mode write, and later captures come every four rising edges after that.
- R4: With mode 4'b0111 only every sixteenth rising edge captures, counted the same way as in R3.
- R5: With mode 4'b0011 a capture happens in each cycle where `stamp_i` is 1. Pin edges capture nothing in this mode.
- R6: Mode 4'b0000 switches the unit off. No capture occurs, and the prescaler count is held at zero.
- R7: A bus write with `bus_addr_i`=0 loads `bus_wdata_i` as the new mode and restarts the prescaler count from zero. Any event in the same cycle as that write is discarded.
- R8: Mode codes other than those listed in R1 to R6 never cause a capture.
- R9: Every capture sets `irq_o`. The flag stays set until a bus write with `bus_addr_i`=1 and `bus_wdata_i[0]`=1 clears it. Such a write with bit 0 equal to 0 has no effect. If a capture and a clear fall in the same cycle, the capture wins.
- R10: When the timer advances at the same clock edge as a capture, the capture register takes the value `timer_i` had before that edge.
- R11: After reset, `cap_o` is 0, `irq_o` is 0 and the mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously outside the unit |
| pin_i | input | 1 | Capture input, already synchronized to clk_i |
| stamp_i | input | 1 | Timestamp strobe from the message controller |
| timer_i | input | 16 | Current value of the free-running timer |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 = mode register, 1 = flag clear |
| bus_wdata_i | input | 4 | Write data |
| cap_o | output | 16 | Captured timer value |
| irq_o | output | 1 | Capture interrupt flag |

## Verification
The assertions assume three things about the inputs. `pin_i` carries one clean, already-synchronized sample per clock. `timer_i` and `stamp_i` hold steady around the rising clock edge. Mode writes are the only way the divide setting changes. The bench drives every input only at the falling clock edge. It holds the pin level for at least one full cycle per sample and pulses the strobe for exactly one cycle. Its timer advances at every rising edge, so every capture also checks that the value from before the edge is the one taken.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int unsigned TMR_W  = 16;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned PRE_W  = 4;

  localparam logic [MODE_W-1:0] MODE_OFF    = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_STAMP  = 4'b0011;
  localparam logic [MODE_W-1:0] MODE_FALL   = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_RISE   = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_RISE4  = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_RISE16 = 4'b0111;

  localparam int unsigned DIV_LO = 4;
  localparam int unsigned DIV_HI = 16;
endpackage

// File: rtl/ecap_edge.sv
module ecap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end

  assign rise_o = smp_i & ~prev_q;
  assign fall_o = ~smp_i & prev_q;

  // R1: a rising edge cannot be seen in two consecutive cycles
  a_r1_rise_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R2: a falling edge cannot be seen in two consecutive cycles
  a_r2_fall_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ecap_presc.sv
module ecap_presc #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == last_i);
  assign cnt_en  = clr_i | step_i;
  assign hit_o   = step_i & ~clr_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6 / R7: a restart leaves the count at zero
  a_r7_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  // R3 / R4: the count never passes the divide limit
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             stamp_i,
  input  logic [TMR_W-1:0] timer_i,
  input  logic             bus_wr_i,
  input  logic             bus_addr_i,
  input  logic [3:0]       bus_wdata_i,
  output logic [TMR_W-1:0] cap_o,
  output logic             irq_o
);
  localparam logic [PRE_W-1:0] LAST_LO = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(DIV_HI - 1);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic              mode_wr;
  logic              flag_clr;
  logic              rise, fall, hit;
  logic              presc_mode, presc_clr, presc_step;
  logic [PRE_W-1:0]  presc_last;
  logic              ev, cap_en;
  logic [TMR_W-1:0]  cap_q, cap_d;
  logic              flag_q, flag_d;

  assign mode_wr  = bus_wr_i & ~bus_addr_i;
  assign flag_clr = bus_wr_i & bus_addr_i & bus_wdata_i[0];

  ecap_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign presc_mode = (mode_q == MODE_RISE4) | (mode_q == MODE_RISE16);
  assign presc_last = (mode_q == MODE_RISE16) ? LAST_HI : LAST_LO;
  assign presc_clr  = mode_wr | (mode_q == MODE_OFF);
  assign presc_step = rise & presc_mode;

  ecap_presc #(.CNT_W(PRE_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (presc_clr),
    .step_i (presc_step),
    .last_i (presc_last),
    .hit_o  (hit)
  );

  always_comb begin
    unique case (mode_q)
      MODE_STAMP:              ev = stamp_i;
      MODE_FALL:               ev = fall;
      MODE_RISE:               ev = rise;
      MODE_RISE4, MODE_RISE16: ev = hit;
      default:                 ev = 1'b0;
    endcase
  end

  assign cap_en = ev & ~mode_wr;

  always_comb begin
    mode_d = mode_wr ? bus_wdata_i : mode_q;
    cap_d  = cap_en ? timer_i : cap_q;
    flag_d = flag_q;
    if (cap_en)        flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mode_wr)           mode_q <= mode_d;
      if (cap_en)            cap_q  <= cap_d;
      if (cap_en | flag_clr) flag_q <= flag_d;
    end
  end

  assign cap_o = cap_q;
  assign irq_o = flag_q;

  // R10: the capture holds the timer value seen before the edge
  a_r10_pre_edge_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |=> (cap_o == $past(timer_i)));
  // R9: a capture always leaves the flag set
  a_r9_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |=> irq_o);
  // R9: without capture or clear, the flag holds
  a_r9_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en && !flag_clr) |=> $stable(irq_o));
  // R6: while off the captured value never moves
  a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF) |=> $stable(cap_o));
  // R7: an event in a mode-write cycle is dropped
  a_r7_write_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> $stable(cap_o));
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        pin_i, stamp_i, bus_wr_i, bus_addr_i;
  logic [3:0]  bus_wdata_i;
  logic [15:0] timer_i;
  logic [15:0] cap_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  // free-running timer, advances at every rising edge (R10)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_i <= 16'h1200;
    else         timer_i <= timer_i + 16'd3;
  end

  edge_capture_unit i_edge_capture_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .stamp_i(stamp_i),
    .timer_i(timer_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .cap_o(cap_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic set_pin(input logic v, output logic [15:0] t);
    t = timer_i;
    pin_i = v;
    @(negedge clk_i);
  endtask

  task automatic pulse(output logic [15:0] t_r, output logic [15:0] t_f);
    set_pin(1'b1, t_r);
    set_pin(1'b0, t_f);
  endtask

  task automatic t_reset();
    chk("R11 cap", cap_o, 16'h0);
    chk("R11 irq", {15'd0, irq_o}, 16'h0);
  endtask

  task automatic t_off();
    logic [15:0] r, f;
    pulse(r, f);
    chk("R6 off no capture", cap_o, 16'h0);
  endtask

  task automatic t_rise();
    logic [15:0] r, f;
    wr(1'b0, 4'b0101);
    pulse(r, f);
    chk("R1 rise capture", cap_o, r);
    chk("R9 irq set", {15'd0, irq_o}, 16'h1);
    pulse(r, f);
    chk("R10 second rise pre-edge value", cap_o, r);
  endtask

  task automatic t_irq();
    wr(1'b1, 4'b0000);
    chk("R9 clear with bit0=0 ignored", {15'd0, irq_o}, 16'h1);
    wr(1'b1, 4'b0001);
    chk("R9 clear", {15'd0, irq_o}, 16'h0);
  endtask

  task automatic t_fall();
    logic [15:0] r, f, old;
    wr(1'b0, 4'b0100);
    old = cap_o;
    set_pin(1'b1, r);
    chk("R2 rise ignored", cap_o, old);
    set_pin(1'b0, f);
    chk("R2 fall capture", cap_o, f);
  endtask

  task automatic t_div(input logic [3:0] m, input int n, input string req);
    logic [15:0] r, f, old;
    wr(1'b0, m);
    for (int k = 0; k < 2; k++) begin
      old = cap_o;
      for (int i = 1; i < n; i++) pulse(r, f);
      chk({req, " early edges ignored"}, cap_o, old);
      pulse(r, f);
      chk({req, " nth edge captures"}, cap_o, r);
    end
  endtask

  task automatic t_restart();
    logic [15:0] r, f, old;
    wr(1'b0, 4'b0110);
    pulse(r, f);
    pulse(r, f);
    wr(1'b0, 4'b0110);
    old = cap_o;
    for (int i = 0; i < 3; i++) pulse(r, f);
    chk("R7 restart count no early capture", cap_o, old);
    pulse(r, f);
    chk("R7 capture after full count", cap_o, r);
  endtask

  task automatic t_drop();
    logic [15:0] f, old;
    wr(1'b0, 4'b0101);
    old = cap_o;
    bus_wr_i = 1'b1; bus_addr_i = 1'b0; bus_wdata_i = 4'b0101; pin_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    chk("R7 event in write cycle dropped", cap_o, old);
    set_pin(1'b0, f);
  endtask

  task automatic t_stamp();
    logic [15:0] r, f, t, old;
    wr(1'b0, 4'b0011);
    old = cap_o;
    pulse(r, f);
    chk("R5 pin ignored", cap_o, old);
    t = timer_i;
    stamp_i = 1'b1;
    @(negedge clk_i);
    stamp_i = 1'b0;
    chk("R5 strobe capture", cap_o, t);
  endtask

  task automatic t_other();
    logic [15:0] r, f, old;
    wr(1'b0, 4'b1100);
    old = cap_o;
    pulse(r, f);
    stamp_i = 1'b1;
    @(negedge clk_i);
    stamp_i = 1'b0;
    chk("R8 other mode no capture", cap_o, old);
    wr(1'b0, 4'b0000);
    pulse(r, f);
    chk("R6 off again no capture", cap_o, old);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pin_i = 1'b0; stamp_i = 1'b0;
    bus_wr_i = 1'b0; bus_addr_i = 1'b0; bus_wdata_i = 4'h0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_off();
    t_rise();
    t_irq();
    t_fall();
    t_div(4'b0110, 4, "R3");
    t_div(4'b0111, 16, "R4");
    t_restart();
    t_drop();
    t_stamp();
    t_other();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule